// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block owns a window of the physical address map, the graphics aperture. Any access that lands inside the window is turned into a fetch of one 32-bit entry from a translation table in system memory. The returned page frame is then combined with the in-page offset to give the final physical address. The window size comes from a small mask byte. Valid masks are thermometer codes, and each additional one bit halves the window. The table base is assembled from three configuration bytes and is always aligned to a 4 KiB page.

Software programs the block through a byte-wide configuration write port with a selector:

| Selector | Target |
|---|---|
| 0 | Size mask |
| 1 | Table base bits [15:8] |
| 2 | Table base bits [23:16] |
| 3 | Table base bits [31:24] |
| 4 | Control (bit 0 enables translation) |

Accesses come in with a valid/ready handshake, and only one is handled at a time. An access is answered with an untranslated zero result when any of these holds:

- translation is disabled;
- the size mask is invalid;
- the address falls outside the window.

Otherwise the entry fetch is issued on a valid/ready memory request channel. The result appears one cycle after the memory response.

Top module: `aperture_xlate`

## Requirements
- R1: After reset the mask is 0, so the aperture size reads 256 MiB (0x1000_0000). The size error flag is low, the table base reads 0, translation is disabled, busy is low and no result or memory request is valid.
- R2: A write to selector 0 keeps only bits [5:0] of the data. Mask 0x00, 0x20, 0x30, 0x38, 0x3C, 0x3E and 0x3F give sizes of 256, 128, 64, 32, 16, 8 and 4 MiB. For example, writing 0xE0 gives 128 MiB.
- R3: Any other stored mask value gives an aperture size of 0 with the size error flag high.
- R4: Selectors 1, 2 and 3 load table base bits [15:8], [23:16] and [31:24]. Bits [11:8] are always zero. A selector of 5 to 7 changes nothing observable.
- R5: With control bit 0 clear, an accepted access produces a result one cycle later with the translated flag low and the address 0, and no memory request is made.
- R6: For an in-window access, the bridge requests the 32-bit entry at the table base plus 4 × ((address − aperture base) >> 12). The request stays valid with a stable address until the memory accepts it.
- R7: One cycle after the memory response, the result is the entry with bits [11:0] cleared, ORed with bits [11:0] of (address − aperture base). The translated flag is high.
- R8: An address below the aperture base, or at or beyond base plus size, or any access while the size is 0, gives the untranslated zero result one cycle after acceptance.
- R9: Busy is high from the cycle after acceptance of an in-window access until the result is presented. Access ready is low while busy.
- R10: A configuration write in the same cycle an access is accepted affects only later accesses. The accepted access uses the table base, size and enable held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_base_i | input | 32 | Aperture window base address |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_sel_i | input | 3 | Configuration target selector |
| cfg_wdata_i | input | 8 | Configuration write data |
| acc_valid_i | input | 1 | Access request valid |
| acc_addr_i | input | 32 | Access address |
| acc_ready_o | output | 1 | Access accepted when high with valid |
| mem_req_valid_o | output | 1 | Table entry read request valid |
| mem_req_addr_o | output | 32 | Table entry address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Table entry data valid |
| mem_rsp_data_i | input | 32 | Table entry data |
| res_valid_o | output | 1 | Result valid (one cycle) |
| res_addr_o | output | 32 | Translated physical address or zero |
| res_xlated_o | output | 1 | Result came from a table walk |
| busy_o | output | 1 | A table fetch is pending |
| ap_size_o | output | 32 | Decoded aperture size in bytes |
| size_err_o | output | 1 | Stored mask is not a legal code |
| tbl_base_o | output | 32 | Current table base address |

## Verification
Acceptance of an access and a configuration write can fall in the same clock cycle. The bench provokes this by raising access valid together with a write that changes the top table base byte. The scoreboard expects a memory request and result computed from the old base, and the later readback of the base shows the new byte. A second access afterwards must fetch from the new base, which confirms that the write landed but was not seen by the access already in flight.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

   // configuration selector codes
   localparam logic [2:0] SEL_MASK  = 3'd0;
   localparam logic [2:0] SEL_BASE0 = 3'd1;
   localparam logic [2:0] SEL_CTRL  = 3'd4;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_REQ  = 2'd1,
      WK_WAIT = 2'd2
   } walk_state_e;

endpackage

// File: rtl/aperture_cfg.sv
module aperture_cfg
   import aperture_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MASK_W   = 6,
   parameter int MAX_LOG2 = 28,
   parameter int PAGE_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_sel_i,
   input  logic [7:0]        cfg_wdata_i,
   output logic              en_o,
   output logic [ADDR_W-1:0] size_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] tbl_base_o
);
   localparam int NBYTES   = (ADDR_W - 8) / 8;
   localparam int LOW_KEEP = PAGE_W - 8;
   localparam logic [7:0] LOW_MASK = 8'hFF << LOW_KEEP;

   if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr
      $error("aperture_cfg: ADDR_W must be a multiple of 8 and at least 16");
   end
   if (PAGE_W < 8 || PAGE_W > 15) begin : g_bad_page
      $error("aperture_cfg: PAGE_W must lie in 8..15");
   end
   if (MAX_LOG2 >= ADDR_W || MAX_LOG2 - MASK_W < PAGE_W) begin : g_bad_size
      $error("aperture_cfg: size range does not fit the address and page width");
   end

   logic [MASK_W-1:0] mask_q;
   logic              en_q;
   logic [7:0]        base_q [NBYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
      end else if (cfg_we_i) begin
         if (cfg_sel_i == SEL_MASK) mask_q <= cfg_wdata_i[MASK_W-1:0];
         if (cfg_sel_i == SEL_CTRL) en_q   <= cfg_wdata_i[0];
      end
   end

   // one register per table-base byte, loaded only on a changed value
   for (genvar j = 0; j < NBYTES; j++) begin : g_base
      localparam logic [7:0] KEEP = (j == 0) ? LOW_MASK : 8'hFF;
      logic [7:0] nxt;
      assign nxt = cfg_wdata_i & KEEP;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[j] <= '0;
         end else if (cfg_we_i && cfg_sel_i == SEL_BASE0 + 3'(j) && nxt != base_q[j]) begin
            base_q[j] <= nxt;
         end
      end
      assign tbl_base_o[8*j+15:8*j+8] = base_q[j];
   end
   assign tbl_base_o[7:0] = '0;

   // thermometer mask decode: k ones from the top select 2^(MAX_LOG2-k)
   logic [MASK_W:0] hit;
   for (genvar k = 0; k <= MASK_W; k++) begin : g_dec
      localparam logic [MASK_W-1:0] PAT = MASK_W'(((1 << k) - 1) << (MASK_W - k));
      assign hit[k] = (mask_q == PAT);
   end

   always_comb begin
      size_o = '0;
      for (int k = 0; k <= MASK_W; k++) begin
         if (hit[k]) size_o = ADDR_W'(1) << (MAX_LOG2 - k);
      end
   end

   assign err_o = ~|hit;
   assign en_o  = en_q;

endmodule

// File: rtl/aperture_walk.sv
module aperture_walk
   import aperture_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_W     = 12,
   parameter int ENTRY_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ap_base_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] size_i,
   input  logic              err_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic              acc_valid_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   output logic              acc_ready_o,
   output logic              mem_req_valid_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   input  logic              mem_req_ready_i,
   input  logic              mem_rsp_valid_i,
   input  logic [ADDR_W-1:0] mem_rsp_data_i,
   output logic              res_valid_o,
   output logic [ADDR_W-1:0] res_addr_o,
   output logic              res_xlated_o,
   output logic              busy_o
);
   localparam logic [ADDR_W-1:0] POFF_MASK = (ADDR_W'(1) << PAGE_W) - 1'b1;

   walk_state_e       st_q;
   logic [ADDR_W:0]   diff;
   logic              in_win;
   logic              accept;
   logic [ADDR_W-1:0] entry_addr;
   logic [ADDR_W-1:0] req_addr_q;
   logic [ADDR_W-1:0] poff_q;
   logic              res_valid_q;
   logic              res_xl_q;
   logic [ADDR_W-1:0] res_addr_q;

   assign diff       = {1'b0, acc_addr_i} - {1'b0, ap_base_i};
   assign in_win     = en_i && !err_i && !diff[ADDR_W] && (diff[ADDR_W-1:0] < size_i);
   assign accept     = acc_valid_i && (st_q == WK_IDLE);
   assign entry_addr = tbl_base_i + ((diff[ADDR_W-1:0] >> PAGE_W) << ENTRY_LOG2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= WK_IDLE;
         req_addr_q  <= '0;
         poff_q      <= '0;
         res_valid_q <= 1'b0;
         res_xl_q    <= 1'b0;
         res_addr_q  <= '0;
      end else begin
         res_valid_q <= 1'b0;
         unique case (st_q)
            WK_IDLE: begin
               if (accept) begin
                  if (in_win) begin
                     st_q       <= WK_REQ;
                     req_addr_q <= entry_addr;
                     poff_q     <= diff[ADDR_W-1:0] & POFF_MASK;
                  end else begin
                     res_valid_q <= 1'b1;
                     res_xl_q    <= 1'b0;
                     res_addr_q  <= '0;
                  end
               end
            end
            WK_REQ: begin
               if (mem_req_ready_i) st_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid_i) begin
                  st_q        <= WK_IDLE;
                  res_valid_q <= 1'b1;
                  res_xl_q    <= 1'b1;
                  res_addr_q  <= (mem_rsp_data_i & ~POFF_MASK) | poff_q;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign acc_ready_o     = (st_q == WK_IDLE);
   assign busy_o          = (st_q != WK_IDLE);
   assign mem_req_valid_o = (st_q == WK_REQ);
   assign mem_req_addr_o  = req_addr_q;
   assign res_valid_o     = res_valid_q;
   assign res_xlated_o    = res_xl_q;
   assign res_addr_o      = res_addr_q;

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
   parameter int ADDR_W     = 32,
   parameter int MASK_W     = 6,
   parameter int MAX_LOG2   = 28,
   parameter int PAGE_W     = 12,
   parameter int ENTRY_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ap_base_i,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_sel_i,
   input  logic [7:0]        cfg_wdata_i,
   input  logic              acc_valid_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   output logic              acc_ready_o,
   output logic              mem_req_valid_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   input  logic              mem_req_ready_i,
   input  logic              mem_rsp_valid_i,
   input  logic [ADDR_W-1:0] mem_rsp_data_i,
   output logic              res_valid_o,
   output logic [ADDR_W-1:0] res_addr_o,
   output logic              res_xlated_o,
   output logic              busy_o,
   output logic [ADDR_W-1:0] ap_size_o,
   output logic              size_err_o,
   output logic [ADDR_W-1:0] tbl_base_o
);
   if (ENTRY_LOG2 < 0 || ENTRY_LOG2 >= PAGE_W) begin : g_bad_entry
      $error("aperture_xlate: ENTRY_LOG2 out of range");
   end

   logic en;

   aperture_cfg #(
      .ADDR_W(ADDR_W), .MASK_W(MASK_W), .MAX_LOG2(MAX_LOG2), .PAGE_W(PAGE_W)
   ) cfg_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (cfg_we_i),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i),
      .en_o        (en),
      .size_o      (ap_size_o),
      .err_o       (size_err_o),
      .tbl_base_o  (tbl_base_o)
   );

   aperture_walk #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ENTRY_LOG2(ENTRY_LOG2)
   ) walk_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .ap_base_i       (ap_base_i),
      .en_i            (en),
      .size_i          (ap_size_o),
      .err_i           (size_err_o),
      .tbl_base_i      (tbl_base_o),
      .acc_valid_i     (acc_valid_i),
      .acc_addr_i      (acc_addr_i),
      .acc_ready_o     (acc_ready_o),
      .mem_req_valid_o (mem_req_valid_o),
      .mem_req_addr_o  (mem_req_addr_o),
      .mem_req_ready_i (mem_req_ready_i),
      .mem_rsp_valid_i (mem_rsp_valid_i),
      .mem_rsp_data_i  (mem_rsp_data_i),
      .res_valid_o     (res_valid_o),
      .res_addr_o      (res_addr_o),
      .res_xlated_o    (res_xlated_o),
      .busy_o          (busy_o)
   );

endmodule

// File: rtl/aperture_xlate_chk.sv
module aperture_xlate_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_ready_o,
   input logic              mem_req_valid_o,
   input logic [ADDR_W-1:0] mem_req_addr_o,
   input logic              mem_req_ready_i,
   input logic              mem_rsp_valid_i,
   input logic              res_valid_o,
   input logic [ADDR_W-1:0] res_addr_o,
   input logic              res_xlated_o,
   input logic              busy_o,
   input logic [ADDR_W-1:0] ap_size_o,
   input logic              size_err_o
);
   // R9
   busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !acc_ready_o);

   // R9
   req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> busy_o);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

   // R6
   req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> mem_req_addr_o[1:0] == 2'b00);

   // R3
   err_zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_err_o |-> ap_size_o == '0);

   // R8
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && !res_xlated_o |-> res_addr_o == '0);

   // R7
   xlate_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid_i && busy_o && !mem_req_valid_o |=> res_valid_o && res_xlated_o);

endmodule

bind aperture_xlate aperture_xlate_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/aperture_xlate_tb_top.sv
module aperture_xlate_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ap_base = 32'hE000_0000;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_ready;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic [31:0] res_addr;
   logic        res_xlated;
   logic        busy;
   logic [31:0] ap_size;
   logic        size_err;
   logic [31:0] tbl_base;

   int n_chk = 0;
   int n_fail = 0;
   logic [32:0] exp_q [$];
   logic [31:0] exp_entry = '0;
   int          req_count = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aperture_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .ap_base_i(ap_base),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
      .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_ready_o(acc_ready),
      .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
      .mem_req_ready_i(mem_req_ready), .mem_rsp_valid_i(mem_rsp_valid),
      .mem_rsp_data_i(mem_rsp_data), .res_valid_o(res_valid), .res_addr_o(res_addr),
      .res_xlated_o(res_xlated), .busy_o(busy), .ap_size_o(ap_size),
      .size_err_o(size_err), .tbl_base_o(tbl_base)
   );

   function automatic logic [31:0] mem_model(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h0000_05A5;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // memory responder: stalls two cycles, then accepts, then answers
   initial begin
      int stall = 0;
      bit pend = 0;
      logic [31:0] pend_addr = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_model(pend_addr);
            pend = 0;
         end
         if (mem_req_ready) begin
            mem_req_ready = 1'b0;
            req_count++;
         end else if (mem_req_valid) begin
            check(mem_req_addr == exp_entry, "R6 entry address", mem_req_addr, exp_entry);
            stall++;
            if (stall >= 2) begin
               mem_req_ready = 1'b1;
               pend = 1;
               pend_addr = mem_req_addr;
               stall = 0;
            end
         end
      end
   end

   // monitor: compares each result with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5/R7/R8 unexpected result", res_addr, 32'h0);
            end else begin
               logic [32:0] e;
               e = exp_q.pop_front();
               check(res_xlated == e[32], "R5/R7/R8 translated flag", {31'b0, res_xlated}, {31'b0, e[32]});
               check(res_addr == e[31:0], "R5/R7/R8 result address", res_addr, e[31:0]);
            end
         end
      end
   end

   task automatic cfg_write(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_done();
      while (exp_q.size() != 0 || busy) @(negedge clk);
      @(negedge clk);
   endtask

   // driver: predicts and pushes the expected result, then issues the access
   task automatic do_access(input logic [31:0] a, input bit en, input logic [31:0] size,
                            input logic [31:0] base, input bit side_wr, input logic [7:0] side_d);
      logic [32:0] off;
      bit hit;
      off = {1'b0, a} - {1'b0, ap_base};
      hit = en && size != 0 && !off[32] && off[31:0] < size;
      exp_entry = base + ((off[31:0] >> 12) << 2);
      if (hit) exp_q.push_back({1'b1, (mem_model(exp_entry) & 32'hFFFF_F000) | (off[31:0] & 32'hFFF)});
      else     exp_q.push_back({1'b0, 32'h0});
      @(negedge clk);
      check(acc_ready, "R9 ready when idle", {31'b0, acc_ready}, 32'h1);
      acc_valid = 1'b1; acc_addr = a;
      if (side_wr) begin cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = side_d; end
      @(negedge clk);
      acc_valid = 1'b0; cfg_we = 1'b0;
      if (hit) begin
         check(busy && !acc_ready, "R9 busy after accept", {30'b0, busy, acc_ready}, 32'h2);
      end
      wait_done();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int rc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ap_size == 32'h1000_0000, "R1 size after reset", ap_size, 32'h1000_0000);
      check(!size_err, "R1 error flag", {31'b0, size_err}, 32'h0);
      check(tbl_base == 32'h0, "R1 table base", tbl_base, 32'h0);
      check(!busy && !res_valid && !mem_req_valid, "R1 idle outputs",
            {29'b0, busy, res_valid, mem_req_valid}, 32'h0);

      // R2 mask decode
      begin
         logic [7:0]  m [7] = '{8'h00, 8'h20, 8'h30, 8'h38, 8'h3C, 8'h3E, 8'h3F};
         for (int k = 0; k < 7; k++) begin
            cfg_write(3'd0, m[k]);
            check(ap_size == (32'h1000_0000 >> k) && !size_err, "R2 mask decode", ap_size, 32'h1000_0000 >> k);
         end
      end
      cfg_write(3'd0, 8'hE0);
      check(ap_size == 32'h0800_0000, "R2 upper mask bits dropped", ap_size, 32'h0800_0000);

      // R3 invalid masks
      cfg_write(3'd0, 8'h21);
      check(ap_size == 0 && size_err, "R3 invalid mask 0x21", ap_size, 32'h0);
      cfg_write(3'd0, 8'h10);
      check(ap_size == 0 && size_err, "R3 invalid mask 0x10", ap_size, 32'h0);

      // R4 base bytes
      cfg_write(3'd1, 8'h5F);
      cfg_write(3'd2, 8'h34);
      cfg_write(3'd3, 8'h12);
      check(tbl_base == 32'h1234_5000, "R4 base assembly", tbl_base, 32'h1234_5000);
      cfg_write(3'd3, 8'h12);
      cfg_write(3'd6, 8'hAA);
      check(tbl_base == 32'h1234_5000, "R4 rewrite and unused selector", tbl_base, 32'h1234_5000);

      // R5 disabled: valid mask, in window, no fetch
      cfg_write(3'd0, 8'h3C);
      rc = req_count;
      do_access(32'hE012_3456, 1'b0, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      check(req_count == rc, "R5 no memory request when disabled", req_count, rc);

      // R6/R7 translation
      cfg_write(3'd4, 8'h01);
      do_access(32'hE012_3456, 1'b1, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      do_access(32'hE0FF_FFFF, 1'b1, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      do_access(32'hE000_0000, 1'b1, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      check(req_count == rc + 3, "R6 one fetch per translation", req_count, rc + 3);

      // R8 outside the window, and zero size
      rc = req_count;
      do_access(32'hE100_0000, 1'b1, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      do_access(32'hDFFF_FFFF, 1'b1, 32'h0100_0000, 32'h1234_5000, 1'b0, 8'h0);
      cfg_write(3'd0, 8'h3D);
      do_access(32'hE000_1000, 1'b1, 32'h0, 32'h1234_5000, 1'b0, 8'h0);
      check(req_count == rc, "R8 no fetch on miss", req_count, rc);

      // R10 base write in the acceptance cycle
      cfg_write(3'd0, 8'h00);
      do_access(32'hE7AB_C123, 1'b1, 32'h1000_0000, 32'h1234_5000, 1'b1, 8'h77);
      check(tbl_base == 32'h7734_5000, "R10 write landed", tbl_base, 32'h7734_5000);
      do_access(32'hE7AB_C123, 1'b1, 32'h1000_0000, 32'h7734_5000, 1'b0, 8'h0);

      // R1 reset clears configuration again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(tbl_base == 0 && ap_size == 32'h1000_0000, "R1 reset clears base and mask", tbl_base, 32'h0);
      do_access(32'hE000_2000, 1'b0, 32'h1000_0000, 32'h0, 1'b0, 8'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule